// File: doc/BRIEF.md
# Disk Command Chain Sequencer

This block drives a disk controller from a linked list of command blocks kept in a word-addressed memory. On every sector pulse it reads a chain pointer from a fixed five-word control area. A zero pointer leaves it idle; it only copies the live drive status into the sector-mark status word. A non-zero pointer starts the work on the command block it names.

For each command block the sequencer first checks the seal word. It then selects the drive, but only when the drive differs from the last one used. It seeks only when the cylinder differs from the last one used. Next it selects the head once the output FIFO has drained, and it hunts for the requested sector within a bounded number of sector times. After that it walks the six-word sub-command groups. For each group it sends a command tag, a count word and, for writes, the data words, and it writes back a completion status. A zero command word ends the chain. The word after it supplies an interrupt mask, which is ORed into a pending register, and the next-block pointer becomes the new chain pointer. A failure stops the chain at once. The sequencer then writes an encoded reason into the abort word, clears the tags and zeroes the chain pointer.

Top module: `dcc_seq`

## Requirements
- R1: After synchronous reset `active`, `out_valid`, `mem_req` and `irq_pending` are all zero.
- R2: On a sector pulse with a zero chain pointer (control word 0), the block writes the drive status into control word 3 and emits no output word.
- R3: A seal (block word 4) other than 16'hA5A5 writes 16'h0012 to control word 4, emits one tag word 0 and writes 0 to control word 0.
- R4: When block word 2 differs from control word 1, the block emits tag 16'h7F00 OR the drive's low byte. It stores the drive in control word 1, writes 16'hFFFF to control word 2 and waits for the next sector pulse. An equal drive emits no such tag.
- R5: A seek tag, 16'h5000 OR cylinder bits 11:0, is emitted only when bits 11:0 of block word 0 differ from control word 2. The cylinder is then stored in control word 2 and the block waits one sector pulse.
- R6: The head tag is 16'h3000 OR the high byte of block word 1. It is emitted only while `out_empty` is high.
- R7: Before the first read (cmd bit 6) or write (cmd bit 7) group, the block waits until drive status bits 3:0 equal block word 1 bits 3:0 with status bit 10 clear. After 64 failed checks it aborts with code 16'h0402 if bit 10 is set, else 16'h0003.
- R8: If drive status bit 8 is set after drive selection, the block aborts with code 16'h0102 unless the first command word has bit 3 set.
- R9: Each non-zero command emits tag 16'h1000 OR its bits 11:0. A read or write then emits data word count+1; a write follows with `count` data words read from the group's address, and then writes (status AND 16'hFFE0)+1 to group word 5.
- R10: A command with neither bit 6 nor bit 7 set emits tag 16'h0002 after its command tag.
- R11: A zero command word ORs the following word into `irq_pending` and copies block word 3 into control word 0.
- R12: An output word is transferred only in a cycle with `out_valid` high and `out_full` low; while full, the word is held unchanged.
- R13: At most one memory access is outstanding; `mem_req` and its address stay stable until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sector_pulse | input | 1 | One-cycle sector mark from the drive |
| drv_status | input | DW | Drive status: next sector in 3:0, write-late in 8, not-ready in 10 |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | DW | Read data |
| out_valid | output | 1 | Output word present |
| out_tag | output | 1 | Output word is a tag (else data) |
| out_word | output | DW | Tag or data word |
| out_full | input | 1 | Output FIFO full |
| out_empty | input | 1 | Output FIFO drained |
| irq_pending | output | DW | Accumulated interrupt mask bits |
| active | output | 1 | Sequencer is off its idle state |

## Verification
The bench tracks the last drive and cylinder on its own, so a design that skips the forced seek after a drive change, or that seeks on every block, emits a tag sequence that does not match. The abort cases differ only in a stored code word. Each one is driven separately: a broken seal, write-late with and without the reset bit, a sector that never arrives, and a drive that stays not-ready. A wrong code, a missing clear tag or a chain that is left running is caught at the memory and output ports. A full input that toggles every cycle shows whether a design drops or repeats words when the FIFO applies back-pressure.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  localparam logic [15:0] SEAL_WORD   = 16'hA5A5;
  localparam logic [15:0] TAG_DRIVE   = 16'h7F00;
  localparam logic [15:0] TAG_SEEK    = 16'h5000;
  localparam logic [15:0] TAG_HEAD    = 16'h3000;
  localparam logic [15:0] TAG_CMD     = 16'h1000;
  localparam logic [15:0] TAG_REZERO  = 16'h0002;
  localparam logic [15:0] STAT_KEEP   = 16'hFFE0;
  localparam logic [15:0] AB_SEAL     = 16'h0010;
  localparam logic [15:0] AB_WLATE    = 16'h0100;
  localparam logic [15:0] AB_NOTRDY   = 16'h0400;
  localparam logic [15:0] AB_SECTOR   = 16'h0001;
  localparam int          CMD_WR_BIT  = 7;
  localparam int          CMD_RD_BIT  = 6;
  localparam int          CMD_RST_BIT = 3;
  localparam int          GROUP_LEN   = 6;

  typedef enum logic [5:0] {
    ST_IDLE, ST_PTR, ST_SMSTAT, ST_SEAL, ST_DRV, ST_LDRV, ST_DTAG, ST_WDRV,
    ST_WCYLF, ST_DWAIT, ST_WLCHK, ST_WLCMD, ST_CYL, ST_LCYL, ST_STAG, ST_WCYL,
    ST_SWAIT, ST_HEAD, ST_HTAG, ST_CMD, ST_SECCHK, ST_SECWAIT, ST_CTAG,
    ST_RSTTAG, ST_CNT, ST_DCNT, ST_ADDR, ST_DRD, ST_DOUT, ST_WSTAT, ST_MASK,
    ST_NEXT, ST_WPTR, ST_ABW, ST_ABTAG, ST_ABPTR
  } seq_state_t;
endpackage

// File: rtl/dcc_memport.sv
module dcc_memport #(
  parameter int DW = 16,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          go_we,
  input  logic [AW-1:0] go_addr,
  input  logic [DW-1:0] go_wdata,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      done      <= 1'b0;
      rdata     <= '0;
    end else begin
      done <= 1'b0;
      if (go && !mem_req) begin
        mem_req   <= 1'b1;
        mem_we    <= go_we;
        mem_addr  <= go_addr;
        mem_wdata <= go_wdata;
      end else if (mem_req && mem_ack) begin
        mem_req <= 1'b0;
        done    <= 1'b1;
        rdata   <= mem_rdata;
      end
    end
  end

  // R13: request and address held until acknowledged
  p_req_hold_r13: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  p_no_second_go_r13: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !go);
endmodule

// File: rtl/dcc_outport.sv
module dcc_outport #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          push_tag,
  input  logic [DW-1:0] push_word,
  output logic          rdy,
  output logic          out_valid,
  output logic          out_tag,
  output logic [DW-1:0] out_word,
  input  logic          out_full
);
  assign rdy = !out_valid || !out_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_tag   <= 1'b0;
      out_word  <= '0;
    end else if (push) begin
      out_valid <= 1'b1;
      out_tag   <= push_tag;
      out_word  <= push_word;
    end else if (!out_full) begin
      out_valid <= 1'b0;
    end
  end

  // R12: a word blocked by a full FIFO stays put
  p_hold_full_r12: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_full) |=> (out_valid && $stable(out_word) && $stable(out_tag)));
endmodule

// File: rtl/dcc_secmatch.sv
module dcc_secmatch #(
  parameter int DW     = 16,
  parameter int SEC_W  = 4,
  parameter int NR_BIT = 10
) (
  input  logic [DW-1:0]    status,
  input  logic [SEC_W-1:0] want,
  output logic             hit,
  output logic             not_ready
);
  always_comb begin
    not_ready = status[NR_BIT];
    hit       = (status[SEC_W-1:0] == want) && !status[NR_BIT];
  end
endmodule

// File: rtl/dcc_seq.sv
module dcc_seq
  import dcc_pkg::*;
#(
  parameter int            DW        = 16,
  parameter int            AW        = 16,
  parameter logic [15:0]   CB_BASE   = 16'h0040,
  parameter int            MAX_TRIES = 64,
  parameter int            SEC_W     = 4,
  parameter int            NR_BIT    = 10,
  parameter int            WL_BIT    = 8,
  parameter int            CYL_W     = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sector_pulse,
  input  logic [DW-1:0] drv_status,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          out_valid,
  output logic          out_tag,
  output logic [DW-1:0] out_word,
  input  logic          out_full,
  input  logic          out_empty,
  output logic [DW-1:0] irq_pending,
  output logic          active
);
  localparam int          TRY_W  = $clog2(MAX_TRIES + 1);
  localparam logic [AW-1:0] CB_PTR = AW'(CB_BASE);
  localparam logic [AW-1:0] CB_DRV = AW'(CB_BASE + 16'd1);
  localparam logic [AW-1:0] CB_CYL = AW'(CB_BASE + 16'd2);
  localparam logic [AW-1:0] CB_SM  = AW'(CB_BASE + 16'd3);
  localparam logic [AW-1:0] CB_AB  = AW'(CB_BASE + 16'd4);

  seq_state_t        st;
  logic              pend;
  logic [AW-1:0]     ptr, gp, dptr;
  logic [DW-1:0]     drv, cyl, cmd, cnt, left, dword, code;
  logic [7:0]        head;
  logic [SEC_W-1:0]  sec;
  logic              first;
  logic [TRY_W-1:0]  tries;

  logic              m_need, m_we;
  logic [AW-1:0]     m_addr;
  logic [DW-1:0]     m_wdata;
  logic              o_need, o_tag;
  logic [DW-1:0]     o_word;
  logic              mp_go, mp_done;
  logic [DW-1:0]     mp_rdata;
  logic              op_push, op_rdy;
  logic              sm_hit, sm_nr;
  logic              cmd_rw;

  assign mp_go   = m_need && !pend;
  assign op_push = o_need && op_rdy;
  assign active  = (st != ST_IDLE);
  assign cmd_rw  = cmd[CMD_WR_BIT] || cmd[CMD_RD_BIT];

  dcc_memport #(.DW(DW), .AW(AW)) u_mem (
    .clk(clk), .rst(rst), .go(mp_go), .go_we(m_we), .go_addr(m_addr),
    .go_wdata(m_wdata), .done(mp_done), .rdata(mp_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  dcc_outport #(.DW(DW)) u_out (
    .clk(clk), .rst(rst), .push(op_push), .push_tag(o_tag), .push_word(o_word),
    .rdy(op_rdy), .out_valid(out_valid), .out_tag(out_tag), .out_word(out_word),
    .out_full(out_full)
  );

  dcc_secmatch #(.DW(DW), .SEC_W(SEC_W), .NR_BIT(NR_BIT)) u_sec (
    .status(drv_status), .want(sec), .hit(sm_hit), .not_ready(sm_nr)
  );

  // Per-state memory access and output word
  always_comb begin
    m_need  = 1'b0;
    m_we    = 1'b0;
    m_addr  = '0;
    m_wdata = '0;
    o_need  = 1'b0;
    o_tag   = 1'b1;
    o_word  = '0;
    case (st)
      ST_PTR:    begin m_need = 1'b1; m_addr = CB_PTR; end
      ST_SMSTAT: begin m_need = 1'b1; m_we = 1'b1; m_addr = CB_SM; m_wdata = drv_status; end
      ST_SEAL:   begin m_need = 1'b1; m_addr = ptr + AW'(4); end
      ST_DRV:    begin m_need = 1'b1; m_addr = ptr + AW'(2); end
      ST_LDRV:   begin m_need = 1'b1; m_addr = CB_DRV; end
      ST_DTAG:   begin o_need = 1'b1; o_word = DW'(TAG_DRIVE) | DW'(drv[7:0]); end
      ST_WDRV:   begin m_need = 1'b1; m_we = 1'b1; m_addr = CB_DRV; m_wdata = drv; end
      ST_WCYLF:  begin m_need = 1'b1; m_we = 1'b1; m_addr = CB_CYL; m_wdata = '1; end
      ST_WLCMD:  begin m_need = 1'b1; m_addr = ptr + AW'(5); end
      ST_CYL:    begin m_need = 1'b1; m_addr = ptr; end
      ST_LCYL:   begin m_need = 1'b1; m_addr = CB_CYL; end
      ST_STAG:   begin o_need = 1'b1; o_word = DW'(TAG_SEEK) | DW'(cyl[CYL_W-1:0]); end
      ST_WCYL:   begin m_need = 1'b1; m_we = 1'b1; m_addr = CB_CYL; m_wdata = cyl; end
      ST_HEAD:   begin m_need = 1'b1; m_addr = ptr + AW'(1); end
      ST_HTAG:   begin o_need = out_empty; o_word = DW'(TAG_HEAD) | DW'(head); end
      ST_CMD:    begin m_need = 1'b1; m_addr = gp; end
      ST_CTAG:   begin o_need = 1'b1; o_word = DW'(TAG_CMD) | DW'(cmd[CYL_W-1:0]); end
      ST_RSTTAG: begin o_need = 1'b1; o_word = DW'(TAG_REZERO); end
      ST_CNT:    begin m_need = 1'b1; m_addr = gp + AW'(1); end
      ST_DCNT:   begin o_need = 1'b1; o_tag = 1'b0; o_word = cnt + DW'(1); end
      ST_ADDR:   begin m_need = 1'b1; m_addr = gp + AW'(2); end
      ST_DRD:    begin m_need = 1'b1; m_addr = dptr; end
      ST_DOUT:   begin o_need = 1'b1; o_tag = 1'b0; o_word = dword; end
      ST_WSTAT:  begin
        m_need = 1'b1; m_we = 1'b1; m_addr = gp + AW'(5);
        m_wdata = (drv_status & DW'(STAT_KEEP)) + DW'(1);
      end
      ST_MASK:   begin m_need = 1'b1; m_addr = gp + AW'(1); end
      ST_NEXT:   begin m_need = 1'b1; m_addr = ptr + AW'(3); end
      ST_WPTR:   begin m_need = 1'b1; m_we = 1'b1; m_addr = CB_PTR; m_wdata = dword; end
      ST_ABW:    begin m_need = 1'b1; m_we = 1'b1; m_addr = CB_AB; m_wdata = code + DW'(2); end
      ST_ABTAG:  begin o_need = 1'b1; o_word = '0; end
      ST_ABPTR:  begin m_need = 1'b1; m_we = 1'b1; m_addr = CB_PTR; m_wdata = '0; end
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      pend        <= 1'b0;
      ptr         <= '0;
      gp          <= '0;
      dptr        <= '0;
      drv         <= '0;
      cyl         <= '0;
      cmd         <= '0;
      cnt         <= '0;
      left        <= '0;
      dword       <= '0;
      code        <= '0;
      head        <= '0;
      sec         <= '0;
      first       <= 1'b0;
      tries       <= '0;
      irq_pending <= '0;
    end else begin
      if (mp_go)   pend <= 1'b1;
      if (mp_done) pend <= 1'b0;
      case (st)
        ST_IDLE:   if (sector_pulse) st <= ST_PTR;
        ST_PTR:    if (mp_done) begin
          ptr <= AW'(mp_rdata);
          st  <= (mp_rdata == '0) ? ST_SMSTAT : ST_SEAL;
        end
        ST_SMSTAT: if (mp_done) st <= ST_IDLE;
        ST_SEAL:   if (mp_done) begin
          if (mp_rdata != DW'(SEAL_WORD)) begin
            code <= DW'(AB_SEAL);
            st   <= ST_ABW;
          end else begin
            st <= ST_DRV;
          end
        end
        ST_DRV:    if (mp_done) begin drv <= mp_rdata; st <= ST_LDRV; end
        ST_LDRV:   if (mp_done) st <= (mp_rdata != drv) ? ST_DTAG : ST_WLCHK;
        ST_DTAG:   if (op_push) st <= ST_WDRV;
        ST_WDRV:   if (mp_done) st <= ST_WCYLF;
        ST_WCYLF:  if (mp_done) st <= ST_DWAIT;
        ST_DWAIT:  if (sector_pulse) st <= ST_WLCHK;
        ST_WLCHK:  st <= drv_status[WL_BIT] ? ST_WLCMD : ST_CYL;
        ST_WLCMD:  if (mp_done) begin
          if (mp_rdata[CMD_RST_BIT]) begin
            st <= ST_CYL;
          end else begin
            code <= DW'(AB_WLATE);
            st   <= ST_ABW;
          end
        end
        ST_CYL:    if (mp_done) begin cyl <= mp_rdata; st <= ST_LCYL; end
        ST_LCYL:   if (mp_done)
          st <= (mp_rdata[CYL_W-1:0] != cyl[CYL_W-1:0]) ? ST_STAG : ST_HEAD;
        ST_STAG:   if (op_push) st <= ST_WCYL;
        ST_WCYL:   if (mp_done) st <= ST_SWAIT;
        ST_SWAIT:  if (sector_pulse) st <= ST_HEAD;
        ST_HEAD:   if (mp_done) begin
          head <= mp_rdata[15:8];
          sec  <= mp_rdata[SEC_W-1:0];
          st   <= ST_HTAG;
        end
        ST_HTAG:   if (op_push) begin
          gp    <= ptr + AW'(5);
          first <= 1'b1;
          st    <= ST_CMD;
        end
        ST_CMD:    if (mp_done) begin
          cmd <= mp_rdata;
          if (mp_rdata == '0) begin
            st <= ST_MASK;
          end else if ((mp_rdata[CMD_WR_BIT] || mp_rdata[CMD_RD_BIT]) && first) begin
            tries <= '0;
            st    <= ST_SECCHK;
          end else begin
            st <= ST_CTAG;
          end
        end
        ST_SECCHK: begin
          if (sm_hit) begin
            first <= 1'b0;
            st    <= ST_CTAG;
          end else if (tries == TRY_W'(MAX_TRIES - 1)) begin
            code <= sm_nr ? DW'(AB_NOTRDY) : DW'(AB_SECTOR);
            st   <= ST_ABW;
          end else begin
            tries <= tries + TRY_W'(1);
            st    <= ST_SECWAIT;
          end
        end
        ST_SECWAIT: if (sector_pulse) st <= ST_SECCHK;
        ST_CTAG:   if (op_push) st <= cmd_rw ? ST_CNT : ST_RSTTAG;
        ST_RSTTAG: if (op_push) begin gp <= gp + AW'(GROUP_LEN); st <= ST_CMD; end
        ST_CNT:    if (mp_done) begin cnt <= mp_rdata; st <= ST_DCNT; end
        ST_DCNT:   if (op_push) begin
          if (cmd[CMD_WR_BIT]) begin
            st <= ST_ADDR;
          end else begin
            gp <= gp + AW'(GROUP_LEN);
            st <= ST_CMD;
          end
        end
        ST_ADDR:   if (mp_done) begin
          dptr <= AW'(mp_rdata);
          left <= cnt;
          st   <= (cnt == '0) ? ST_WSTAT : ST_DRD;
        end
        ST_DRD:    if (mp_done) begin dword <= mp_rdata; st <= ST_DOUT; end
        ST_DOUT:   if (op_push) begin
          dptr <= dptr + AW'(1);
          left <= left - DW'(1);
          st   <= (left == DW'(1)) ? ST_WSTAT : ST_DRD;
        end
        ST_WSTAT:  if (mp_done) begin gp <= gp + AW'(GROUP_LEN); st <= ST_CMD; end
        ST_MASK:   if (mp_done) begin
          irq_pending <= irq_pending | mp_rdata;
          st          <= ST_NEXT;
        end
        ST_NEXT:   if (mp_done) begin dword <= mp_rdata; st <= ST_WPTR; end
        ST_WPTR:   if (mp_done) st <= ST_IDLE;
        ST_ABW:    if (mp_done) st <= ST_ABTAG;
        ST_ABTAG:  if (op_push) st <= ST_ABPTR;
        ST_ABPTR:  if (mp_done) st <= ST_IDLE;
        default:   st <= ST_IDLE;
      endcase
    end
  end

  // R7: sector search counter never passes its limit
  p_try_bound_r7: assert property (@(posedge clk) disable iff (rst)
    tries < TRY_W'(MAX_TRIES));
  // R3, R7, R8: only defined abort codes reach the abort word
  p_abort_code_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_addr == CB_AB) |->
      (mem_wdata == DW'(16'h0012) || mem_wdata == DW'(16'h0102) ||
       mem_wdata == DW'(16'h0402) || mem_wdata == DW'(16'h0003)));
  // R2: nothing is issued while idle
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> (!op_push && !mp_go));
  // R6: head tag only with a drained FIFO
  p_head_drained_r6: assert property (@(posedge clk) disable iff (rst)
    (op_push && st == ST_HTAG) |-> out_empty);
endmodule

// File: tb/tb_dcc_seq.sv
`timescale 1ns/1ps
module tb_dcc_seq;
  localparam logic [7:0] CB = 8'h40;
  localparam logic [7:0] BP = 8'h80;
  localparam logic [7:0] DA = 8'hC0;
  localparam int NV = 4;
  localparam logic [7:0]  V_DRV  [NV] = '{8'd1, 8'd1, 8'd1, 8'd2};
  localparam logic [15:0] V_CYL  [NV] = '{16'h0123, 16'h0123, 16'h0456, 16'h0456};
  localparam logic [7:0]  V_HEAD [NV] = '{8'd2, 8'd3, 8'd1, 8'd0};
  localparam logic [3:0]  V_SEC  [NV] = '{4'd5, 4'd9, 4'd2, 4'd15};
  localparam logic [15:0] V_CMD  [NV] = '{16'h0080, 16'h0040, 16'h0080, 16'h0080};
  localparam logic [15:0] V_CNT  [NV] = '{16'd3, 16'd4, 16'd1, 16'd0};
  localparam logic [15:0] V_MASK [NV] = '{16'h0004, 16'h0010, 16'h0001, 16'h0002};

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        sector_pulse = 1'b0;
  logic [15:0] drv_status;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata = 16'h0;
  logic        out_valid, out_tag;
  logic [15:0] out_word, irq_pending;
  logic        out_full = 1'b0;
  logic        out_empty = 1'b1;
  logic        active;

  dcc_seq dut (
    .clk(clk), .rst(rst), .sector_pulse(sector_pulse), .drv_status(drv_status),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .out_valid(out_valid), .out_tag(out_tag),
    .out_word(out_word), .out_full(out_full), .out_empty(out_empty),
    .irq_pending(irq_pending), .active(active)
  );

  // memory model, bench writes go through the same process
  logic [15:0] mem [0:255];
  logic        tb_we = 1'b0;
  logic [7:0]  tb_addr = 8'h0;
  logic [15:0] tb_data = 16'h0;
  always @(posedge clk) begin
    if (tb_we) mem[tb_addr] <= tb_data;
    else if (mem_req && mem_we && !mem_ack) mem[mem_addr[7:0]] <= mem_wdata;
    mem_ack   <= mem_req && !mem_ack;
    mem_rdata <= mem[mem_addr[7:0]];
  end

  // drive model: sector pulse every 20 cycles
  logic [4:0]  pc = 5'd0;
  logic [3:0]  st_sec = 4'd0;
  logic        auto_sec = 1'b1, sec_load = 1'b0;
  logic [3:0]  sec_val = 4'd0;
  logic [15:0] st_flags = 16'h0;
  assign drv_status = st_flags | {12'h0, st_sec};
  always @(posedge clk) begin
    if (rst) begin
      pc <= 5'd0;
      sector_pulse <= 1'b0;
    end else begin
      pc <= (pc == 5'd19) ? 5'd0 : pc + 5'd1;
      sector_pulse <= (pc == 5'd19);
    end
    if (sec_load) st_sec <= sec_val;
    else if (sector_pulse && auto_sec) st_sec <= st_sec + 4'd1;
  end

  logic stress = 1'b0;
  always @(negedge clk) out_full <= stress ? ~out_full : 1'b0;

  // output log
  logic        bt [0:63];
  logic [15:0] bw [0:63];
  int          nb = 0;
  logic        log_clr = 1'b0;
  always @(posedge clk) begin
    if (log_clr) nb <= 0;
    else if (out_valid && !out_full && nb < 64) begin
      bt[nb] <= out_tag;
      bw[nb] <= out_word;
      nb <= nb + 1;
    end
  end

  int checks = 0, errors = 0;
  logic        et [0:63];
  logic [15:0] ew [0:63];
  int          ne;
  logic [7:0]  ldrv;
  logic [15:0] lcyl, eirq;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic ex(input logic t, input logic [15:0] w);
    et[ne] = t; ew[ne] = w; ne++;
  endtask

  task automatic cmp_beats(input string r);
    chk({r, " count"}, 32'(nb), 32'(ne));
    for (int i = 0; i < ne && i < nb; i++)
      chk({r, " word"}, {15'h0, bt[i], bw[i]}, {15'h0, et[i], ew[i]});
  endtask

  task automatic mw(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); tb_we = 1'b1; tb_addr = a; tb_data = d;
    @(negedge clk); tb_we = 1'b0;
  endtask

  task automatic exp_drive(input logic [7:0] d);
    if (d != ldrv) begin ex(1'b1, 16'h7F00 | {8'h0, d}); ldrv = d; lcyl = 16'hFFFF; end
  endtask

  task automatic exp_cyl_head(input logic [15:0] c, input logic [7:0] h);
    if (c[11:0] != lcyl[11:0]) begin ex(1'b1, 16'h5000 | {4'h0, c[11:0]}); lcyl = c; end
    ex(1'b1, 16'h3000 | {8'h0, h});
  endtask

  task automatic build(input logic [7:0] d, input logic [15:0] c, input logic [7:0] h,
                       input logic [3:0] s, input logic [15:0] seal, input logic [15:0] cmd,
                       input logic [15:0] cnt, input logic [15:0] mask, input int base);
    mw(BP + 8'd0, c);
    mw(BP + 8'd1, {h, 4'h0, s});
    mw(BP + 8'd2, {8'h0, d});
    mw(BP + 8'd3, 16'h0000);
    mw(BP + 8'd4, seal);
    mw(BP + 8'd5, cmd);
    mw(BP + 8'd6, cnt);
    mw(BP + 8'd7, {8'h0, DA});
    mw(BP + 8'd10, 16'h0000);
    mw(BP + 8'd11, 16'h0000);
    mw(BP + 8'd12, mask);
    for (int i = 0; i < 8; i++) mw(DA + 8'(i), 16'hA000 + 16'(base) + 16'(i));
  endtask

  task automatic run(input string r);
    int n;
    @(negedge clk); log_clr = 1'b1;
    @(negedge clk); log_clr = 1'b0;
    mw(CB, {8'h0, BP});
    n = 0;
    while ((mem[CB] != 16'h0 || active) && n < 20000) begin @(negedge clk); n++; end
    if (n >= 20000) chk({r, " chain finished"}, 32'd0, 32'd1);
  endtask

  task automatic exp_write_body(input logic [15:0] cmd, input logic [15:0] cnt, input int base);
    ex(1'b1, 16'h1000 | {4'h0, cmd[11:0]});
    ex(1'b0, cnt + 16'd1);
    if (cmd[7]) for (int i = 0; i < int'(cnt); i++) ex(1'b0, 16'hA000 + 16'(base) + 16'(i));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    ldrv = 8'h0; lcyl = 16'h0; eirq = 16'h0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 active", 32'(active), 32'd0);
    chk("R1 out_valid", 32'(out_valid), 32'd0);
    chk("R1 mem_req", 32'(mem_req), 32'd0);
    chk("R1 irq_pending", 32'(irq_pending), 32'd0);
    mw(CB, 16'h0); mw(CB + 8'd1, 16'h0); mw(CB + 8'd2, 16'h0);
    mw(CB + 8'd3, 16'h0); mw(CB + 8'd4, 16'h0);

    // R2: idle refresh of sector-mark status
    sec_val = 4'd7; sec_load = 1'b1; auto_sec = 1'b0; st_flags = 16'h0200;
    @(negedge clk); sec_load = 1'b0;
    @(negedge clk); log_clr = 1'b1; @(negedge clk); log_clr = 1'b0;
    repeat (50) @(negedge clk);
    chk("R2 sector-mark status", 32'(mem[CB + 8'd3]), 32'h0207);
    chk("R2 no output", 32'(nb), 32'd0);
    st_flags = 16'h0; auto_sec = 1'b1;

    // vector table: R4 R5 R6 R7 R9 R11 R13
    for (int v = 0; v < NV; v++) begin
      build(V_DRV[v], V_CYL[v], V_HEAD[v], V_SEC[v], 16'hA5A5, V_CMD[v], V_CNT[v],
            V_MASK[v], v * 16);
      ne = 0;
      exp_drive(V_DRV[v]);
      exp_cyl_head(V_CYL[v], V_HEAD[v]);
      exp_write_body(V_CMD[v], V_CNT[v], v * 16);
      eirq = eirq | V_MASK[v];
      run("R9 vector");
      cmp_beats("R4 R5 R6 R9 vector beats");
      chk("R4 stored drive", 32'(mem[CB + 8'd1]), {24'h0, V_DRV[v]});
      chk("R5 stored cylinder", 32'(mem[CB + 8'd2]), 32'(V_CYL[v]));
      if (V_CMD[v][7]) chk("R9 write status", 32'(mem[BP + 8'd10]), 32'h0001);
      chk("R11 irq mask", 32'(irq_pending), 32'(eirq));
      chk("R11 chain pointer", 32'(mem[CB]), 32'h0);
    end

    // R3: bad seal
    build(8'd2, 16'h0456, 8'd1, 4'd1, 16'h1234, 16'h0080, 16'd1, 16'h0100, 0);
    ne = 0; ex(1'b1, 16'h0000);
    run("R3");
    cmp_beats("R3 beats");
    chk("R3 abort word", 32'(mem[CB + 8'd4]), 32'h0012);
    chk("R3 irq untouched", 32'(irq_pending), 32'(eirq));

    // R8: write-late aborts a write command
    st_flags = 16'h0100;
    build(8'd2, 16'h0456, 8'd1, 4'd1, 16'hA5A5, 16'h0080, 16'd1, 16'h0100, 0);
    ne = 0; exp_drive(8'd2); ex(1'b1, 16'h0000);
    run("R8");
    cmp_beats("R8 beats");
    chk("R8 abort word", 32'(mem[CB + 8'd4]), 32'h0102);

    // R8 + R10: reset command survives write-late and sends tag 2
    build(8'd2, 16'h0456, 8'd4, 4'd1, 16'hA5A5, 16'h0008, 16'd0, 16'h0200, 0);
    ne = 0; exp_drive(8'd2); exp_cyl_head(16'h0456, 8'd4);
    ex(1'b1, 16'h1008); ex(1'b1, 16'h0002);
    eirq = eirq | 16'h0200;
    run("R10");
    cmp_beats("R10 beats");
    chk("R8 abort word kept", 32'(mem[CB + 8'd4]), 32'h0102);
    chk("R11 irq after reset cmd", 32'(irq_pending), 32'(eirq));
    st_flags = 16'h0;

    // R7: sector never arrives
    sec_val = 4'd3; sec_load = 1'b1; auto_sec = 1'b0;
    @(negedge clk); sec_load = 1'b0;
    build(8'd2, 16'h0456, 8'd5, 4'd4, 16'hA5A5, 16'h0080, 16'd1, 16'h0100, 0);
    ne = 0; exp_cyl_head(16'h0456, 8'd5); ex(1'b1, 16'h0000);
    run("R7");
    cmp_beats("R7 timeout beats");
    chk("R7 invalid sector code", 32'(mem[CB + 8'd4]), 32'h0003);

    // R7: drive not ready at the right sector
    sec_val = 4'd4; sec_load = 1'b1; st_flags = 16'h0400;
    @(negedge clk); sec_load = 1'b0;
    ne = 0; exp_cyl_head(16'h0456, 8'd5); ex(1'b1, 16'h0000);
    run("R7");
    cmp_beats("R7 not-ready beats");
    chk("R7 not-ready code", 32'(mem[CB + 8'd4]), 32'h0402);
    st_flags = 16'h0; auto_sec = 1'b1;

    // R12: FIFO back-pressure toggling every cycle
    stress = 1'b1;
    build(8'd3, 16'h0777, 8'd6, 4'd8, 16'hA5A5, 16'h0080, 16'd5, 16'h0008, 64);
    ne = 0; exp_drive(8'd3); exp_cyl_head(16'h0777, 8'd6);
    exp_write_body(16'h0080, 16'd5, 64);
    eirq = eirq | 16'h0008;
    run("R12");
    stress = 1'b0;
    cmp_beats("R12 stalled beats");
    chk("R13 stored drive under stall", 32'(mem[CB + 8'd1]), 32'h0003);
    chk("R11 irq under stall", 32'(irq_pending), 32'(eirq));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule